// File: doc/BRIEF.md
# Button press filter with release-started lockout

This block turns a noisy mechanical push-button level into clean press events, all on one fast system clock. The raw level passes through a short flip-flop chain that synchronizes it. A registered copy of the synchronized level, one clock older, is then compared with the current level to find transitions in either direction.

A transition from high to low (a release) arms a countdown. While the countdown runs, any transition from low to high is treated as contact bounce and dropped. A transition from low to high that arrives while no countdown is running gives a press pulse that lasts one clock. The length of the countdown is set by a counter-width parameter. The block also reports whether a countdown is running. The press pulse goes to the logic that consumes presses, for example a length or mode stepper.

Top module: `btn_lockout_filter`

## Requirements
- R1: The raw input passes through `SYNC_STAGES` (default 2) flip-flops and one delay register, so a clean low-to-high change of `btn_raw` set up before clock edge 1 makes `press_pulse` high in the cycle after clock edge 3, and not earlier.
- R2: A press edge accepted while no lockout runs gives exactly one `press_pulse` cycle, however long the button stays high.
- R3: A release edge (delayed copy high, current synchronized level low) loads the lockout counter with all ones. `lockout_active` is then high for exactly 2^`CNT_W`-1 consecutive cycles.
- R4: A press edge that is seen while `lockout_active` is high produces no `press_pulse`.
- R5: A release edge seen while a lockout is already running reloads the counter to all ones, which lengthens the lockout.
- R6: Reset is synchronous and active low. While `rst_n` is low at a clock edge, the synchronizer, the delay register, the counter and `press_pulse` clear, so both outputs read 0 after that edge, even in the middle of a lockout.
- R7: When the lockout counter has reached zero, the next press edge is accepted again.
- R8: `lockout_active` is high exactly when the lockout counter is nonzero. The counter decrements by one per clock and stops at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| btn_raw | input | 1 | Raw button level, asynchronous and bouncing |
| press_pulse | output | 1 | One-clock pulse for each accepted press |
| lockout_active | output | 1 | High while the release lockout counts down |

## Verification
A wrong counter state shows up at the ports within one countdown window. It appears either as a change in how many cycles `lockout_active` stays high after a release, or as a press pulse that gets through, or gets lost, right after that window. A fault in the synchronizer or the edge register moves the press pulse away from its fixed third-cycle latency, or gives a second pulse for a held button, within a handful of clocks. A reload fault appears when a bounce falls inside a running lockout, because the flag then drops early.

// File: rtl/btn_filter_pkg.sv
// Package: shared types for the button lockout filter.
// Assumes: nothing beyond IEEE 1800-2017.
package btn_filter_pkg;
    // Transition seen between the delayed and the current synchronized level.
    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } edge_kind_t;
endpackage

// File: rtl/btn_sync_chain.sv
// Module: chain of flip-flops that brings an asynchronous level into clk.
// Assumes: STAGES >= 1; reset is synchronous, active low, and clears every stage.
module btn_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] stage_q;

    // Stage 0 captures the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= 1'b0;
        else        stage_q[0] <= d_async;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            // Each later stage copies the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[i] <= 1'b0;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/btn_edge_detect.sv
// Module: classifies a synchronized level against its one-clock-old copy.
// Assumes: the input is already synchronous to clk; the output is combinational.
module btn_edge_detect
    import btn_filter_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level,
    output edge_kind_t edge_kind
);
    logic level_d;

    // Keep the previous level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level;
    end

    // Decode the transition kind.
    always_comb begin
        if (level && !level_d)      edge_kind = EDGE_RISE;
        else if (!level && level_d) edge_kind = EDGE_FALL;
        else                        edge_kind = EDGE_NONE;
    end
endmodule

// File: rtl/lockout_timer.sv
// Module: saturating down-counter that is armed by a start strobe.
// Assumes: a start strobe reloads the counter even when it is already running.
module lockout_timer #(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic [CNT_W-1:0] count,
    output logic             running
);
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ZERO = {CNT_W{1'b0}};

    // Load on start, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)             count <= ZERO;
        else if (start)         count <= FULL;
        else if (count != ZERO) count <= count - 1'b1;
    end

    assign running = (count != ZERO);
endmodule

// File: rtl/btn_lockout_filter.sv
// Module: top of the button filter. Synchronizes the raw level, finds edges,
// starts a lockout on release and passes a press only when no lockout runs.
// Assumes: btn_raw may be asynchronous; the reset is synchronous and active low.
module btn_lockout_filter
    import btn_filter_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 21
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw,
    output logic press_pulse,
    output logic lockout_active
);
    logic             btn_sync;
    edge_kind_t       edge_kind;
    logic             fall_evt;
    logic [CNT_W-1:0] lock_cnt;

    btn_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (btn_raw),
        .q_sync  (btn_sync)
    );

    btn_edge_detect u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (btn_sync),
        .edge_kind (edge_kind)
    );

    assign fall_evt = (edge_kind == EDGE_FALL);

    lockout_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (fall_evt),
        .count   (lock_cnt),
        .running (lockout_active)
    );

    // Register one press pulse for a rise edge that arrives outside any lockout.
    always_ff @(posedge clk) begin
        if (!rst_n) press_pulse <= 1'b0;
        else        press_pulse <= (edge_kind == EDGE_RISE) && !lockout_active;
    end
endmodule

// File: rtl/btn_lockout_filter_chk.sv
// Module: property checker for btn_lockout_filter, attached with bind.
// Assumes: it sees the top ports plus the counter and the release strobe.
module btn_lockout_filter_chk #(
    parameter int CNT_W = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             press,
    input logic             active,
    input logic [CNT_W-1:0] cnt,
    input logic             fall
);
    // R2: a press pulse never lasts more than one cycle.
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        press |=> !press);

    // R4: no press pulse may appear while a lockout is running.
    p_no_press_in_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        press |-> !active);

    // R3, R5: a release strobe leaves the counter full on the next cycle.
    p_release_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> (cnt == {CNT_W{1'b1}}) && active);

    // R8: the counter decrements by exactly one when not reloaded.
    p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !fall) |=> cnt == $past(cnt) - 1'b1);

    // R8: a counter at zero stays at zero without a release.
    p_hold_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !fall) |=> !active);
endmodule

bind btn_lockout_filter btn_lockout_filter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .press  (press_pulse),
    .active (lockout_active),
    .cnt    (lock_cnt),
    .fall   (fall_evt)
);

// File: tb/btn_lockout_filter_bench.sv
`timescale 1ns/1ps
module btn_lockout_filter_bench;
    localparam int CNT_W    = 4;
    localparam int LOCK_LEN = (1 << CNT_W) - 1;

    typedef struct packed {
        logic       lvl;
        logic [7:0] cyc;
        logic [3:0] npulse;
    } vec_t;

    // Level held for cyc clocks and the press pulses expected in that window.
    localparam vec_t VEC [6] = '{
        '{1'b1, 8'd10, 4'd1},  // R2: clean press, one pulse
        '{1'b0, 8'd4,  4'd0},  // R3: release arms the lockout
        '{1'b1, 8'd2,  4'd0},  // R4: bounce inside the lockout
        '{1'b0, 8'd20, 4'd0},  // R5: second release reloads, then expires
        '{1'b1, 8'd6,  4'd1},  // R7: press accepted after expiry
        '{1'b1, 8'd10, 4'd0}   // R2: held button, no further pulse
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_raw = 1'b0;
    logic press_pulse;
    logic lockout_active;

    int n_run  = 0;
    int n_fail = 0;
    int pulses = 0;
    int act_cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    btn_lockout_filter #(.SYNC_STAGES(2), .CNT_W(CNT_W)) u_btn_lockout_filter (
        .clk            (clk),
        .rst_n          (rst_n),
        .btn_raw        (btn_raw),
        .press_pulse    (press_pulse),
        .lockout_active (lockout_active)
    );

    // Wait for the falling clock edge, then sample and accumulate outputs.
    task automatic tick();
        @(negedge clk);
        pulses     += int'(press_pulse);
        act_cycles += int'(lockout_active);
    endtask

    task automatic check(string req, int actual, int expected);
        n_run++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R6: reset state
        repeat (3) tick();
        check("R6 press after reset", int'(press_pulse), 0);
        check("R6 lockout after reset", int'(lockout_active), 0);
        rst_n = 1'b1;
        repeat (4) tick();

        // Table walk
        foreach (VEC[i]) begin
            btn_raw = VEC[i].lvl;
            pulses = 0;
            for (int c = 0; c < int'(VEC[i].cyc); c++) tick();
            check($sformatf("R2/R4/R5/R7 vector %0d pulses", i), pulses, int'(VEC[i].npulse));
        end

        // R3: lockout length after a single clean release
        btn_raw = 1'b0;
        pulses = 0;
        act_cycles = 0;
        repeat (40) tick();
        check("R3 lockout length", act_cycles, LOCK_LEN);
        check("R3 release makes no pulse", pulses, 0);

        // R5: bounce six clocks into a lockout reloads the counter
        btn_raw = 1'b1;
        repeat (25) tick();
        pulses = 0;
        act_cycles = 0;
        btn_raw = 1'b0;
        repeat (6) tick();
        btn_raw = 1'b1;
        repeat (2) tick();
        btn_raw = 1'b0;
        repeat (32) tick();
        check("R5 reloaded lockout length", act_cycles, LOCK_LEN + 8);
        check("R4 bounce in lockout gives no pulse", pulses, 0);

        // R1: latency from raw rise to pulse
        btn_raw = 1'b1;
        tick();
        tick();
        check("R1 no pulse after edge 2", int'(press_pulse), 0);
        tick();
        check("R1 pulse after edge 3", int'(press_pulse), 1);
        tick();
        check("R2 pulse gone after edge 4", int'(press_pulse), 0);

        // R6: reset in the middle of a lockout
        repeat (4) tick();
        btn_raw = 1'b0;
        repeat (5) tick();
        check("R8 lockout running before reset", int'(lockout_active), 1);
        rst_n = 1'b0;
        tick();
        check("R6 lockout cleared by reset", int'(lockout_active), 0);
        check("R6 press cleared by reset", int'(press_pulse), 0);
        rst_n = 1'b1;
        repeat (3) tick();
        check("R6 no lockout after reset release", int'(lockout_active), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule